// File: doc/BRIEF.md
# Converter serial read-out port with timing watchdog

This block is the device side of a serial read-out link for a 10-bit converter. A host lowers chip select, and the block drives the most recently finished conversion result onto a data line that can be put in high impedance. One result bit is driven per I/O clock, most significant bit first. After the tenth falling edge of the I/O clock, the block sends a one-cycle pulse that asks the analog core to start a new conversion. The analog conversion is not part of this block. The finished result comes back on a data bus, marked by a valid strobe.

Chip select and the I/O clock are sampled by the block's own system clock through two-flop synchronizers, and the block finds their edges internally. Chip select must also hold its new level for a set number of cycles before the block acts on it.

The block also checks the host's timing:
- A transfer must not start while the previous conversion is still in its busy window.
- After the tenth clock, the eleventh rising edge must come quickly.
- A transfer must not run past sixteen clocks.

If the host breaks any of these rules, the block freezes the transfer. The two error conditions also raise a flag that stays set until chip select has gone high and then been validly lowered again.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, dout_oe, dout, conv_start, sync_err and overlen_err are all 0.
- R2: Chip select is active low. Once cs_n has been low for CS_HOLD_CYC consecutive synchronized cycles, dout_oe goes to 1. In the same cycle, dout presents bit DATA_W-1 of the latched result. Once cs_n has been high for CS_HOLD_CYC cycles, dout_oe returns to 0. While dout_oe is 0, dout is 0.
- R3: A change on cs_n that lasts fewer than CS_HOLD_CYC synchronized cycles has no effect on dout_oe.
- R4: While a transfer is running, each I/O clock falling edge moves dout to the next lower result bit. After the k-th falling edge, dout is bit DATA_W-1-k for k < DATA_W. It is 0 for k from DATA_W to MAX_CLKS.
- R5: I/O clock edges have no effect while chip select is high. This covers shifting, conv_start and the error flags.
- R6: conv_start pulses for exactly one cycle after the DATA_W-th falling edge of a transfer. It pulses once per transfer.
- R7: A transfer whose chip-select fall is accepted within BUSY_CYC cycles after a DATA_W-th falling edge is refused. Its clocks do not shift, dout holds the most significant bit, and conv_start does not pulse.
- R8: Suppose the first rising I/O clock edge after the DATA_W-th falling edge arrives LATE_CYC or more cycles after that falling edge. Then sync_err becomes 1, and all further clocks in the transfer are ignored. sync_err stays 1 through the chip-select rise and clears only on the next accepted chip-select fall.
- R9: A falling edge after the MAX_CLKS-th sets overlen_err, and later clocks in that transfer are ignored. overlen_err stays 1 until the next accepted chip-select fall.
- R10: A conv_valid strobe latches conv_data. The latched value is loaded into the output shifter only at an accepted chip-select fall, so a strobe during a transfer does not change the bits of that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from host, active low, asynchronous |
| io_clk | input | 1 | Serial I/O clock from host, asynchronous |
| conv_data | input | DATA_W | Finished conversion result |
| conv_valid | input | 1 | Strobe that latches conv_data |
| dout | output | 1 | Serial data bit, 0 while disabled |
| dout_oe | output | 1 | Output enable for the data pad driver |
| conv_start | output | 1 | One-cycle request to begin a conversion |
| sync_err | output | 1 | Late eleventh clock seen; sticky until the next transfer |
| overlen_err | output | 1 | More than MAX_CLKS clocks seen; sticky until the next transfer |

## Verification
The assertions assume that the host holds cs_n and io_clk steady long enough for the synchronizers and the chip-select filter to settle. They also assume that I/O clock phases are several system cycles long, so that one rising and one falling edge are never seen in the same cycle. The bench keeps to this by holding every io_clk phase for five system cycles. It holds each real chip-select change for CS_HOLD_CYC plus six cycles; only the deliberate glitch case is shorter. The late-clock and busy-window cases are built by placing waits on either side of the LATE_CYC and BUSY_CYC windows. The normal frames keep the eleventh rising edge well inside the late window.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_RUN  = 2'd1,
    FR_HALT = 2'd2
  } frame_st_t;

  // A transfer accepts I/O clock edges only while selected and running.
  function automatic logic frame_accepts(input frame_st_t st, input logic cs_level);
    return (st == FR_RUN) && !cs_level;
  endfunction

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
      end
    end
    assign dout[i] = sync_q;
  end
endmodule

// File: rtl/adc_sp_csfilt.sv
module adc_sp_csfilt #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall,
  output logic rise
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] run_q;
  logic          lvl_q;
  logic          differs;
  logic          accept;

  assign differs = (din != lvl_q);
  assign accept  = differs && (run_q == CW'(HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lvl_q <= 1'b1;
    end else if (!differs) begin
      run_q <= '0;
    end else if (accept) begin
      lvl_q <= din;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level = lvl_q;
  assign fall  = accept & ~din;
  assign rise  = accept & din;
endmodule

// File: rtl/adc_sp_timer.sv
module adc_sp_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (start)          left_q <= TW'(CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int MAX_CLKS    = 16,
  parameter int CS_HOLD_CYC = 178,
  parameter int LATE_CYC    = 1188,
  parameter int BUSY_CYC    = 2625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              io_clk,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              conv_valid,
  output logic              dout,
  output logic              dout_oe,
  output logic              conv_start,
  output logic              sync_err,
  output logic              overlen_err
);
  localparam int CNT_W = $clog2(MAX_CLKS + 2);

  function automatic logic [DATA_W-1:0] shift_once(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], 1'b0};
  endfunction

  // Synchronized pins: bit 1 chip select (idles high), bit 0 I/O clock
  logic [1:0] pins_s;
  adc_sp_sync #(.WIDTH(2), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, io_clk}), .dout(pins_s)
  );

  logic cs_level, cs_fall_w, cs_rise_w;
  adc_sp_csfilt #(.HOLD(CS_HOLD_CYC)) u_csfilt (
    .clk(clk), .rst_n(rst_n), .din(pins_s[1]),
    .level(cs_level), .fall(cs_fall_w), .rise(cs_rise_w)
  );

  logic io_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_d <= 1'b0;
    else        io_d <= pins_s[0];
  end

  frame_st_t         frame_q;
  logic [CNT_W-1:0]  falls_q;
  logic [DATA_W-1:0] shift_q;
  logic [DATA_W-1:0] result_q;
  logic              lost_q, ovl_q, start_q;

  // Named internal events
  logic edge_en, sclk_rise_w, sclk_fall_w, tenth_w, late_w, over_w;
  logic late_open_w, busy_w;

  assign edge_en     = frame_accepts(frame_q, cs_level);
  assign sclk_rise_w = edge_en &  pins_s[0] & ~io_d;
  assign sclk_fall_w = edge_en & ~pins_s[0] &  io_d;
  assign tenth_w     = sclk_fall_w && (falls_q == CNT_W'(DATA_W - 1));
  assign late_w      = sclk_rise_w && (falls_q == CNT_W'(DATA_W)) && !late_open_w;
  assign over_w      = sclk_fall_w && (falls_q == CNT_W'(MAX_CLKS));

  adc_sp_timer #(.CYCLES(LATE_CYC)) u_late_win (
    .clk(clk), .rst_n(rst_n), .start(tenth_w), .active(late_open_w)
  );
  adc_sp_timer #(.CYCLES(BUSY_CYC)) u_busy_win (
    .clk(clk), .rst_n(rst_n), .start(tenth_w), .active(busy_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          result_q <= '0;
    else if (conv_valid) result_q <= conv_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= FR_IDLE;
      falls_q <= '0;
      shift_q <= '0;
      lost_q  <= 1'b0;
      ovl_q   <= 1'b0;
    end else if (cs_fall_w) begin
      frame_q <= busy_w ? FR_HALT : FR_RUN;
      falls_q <= '0;
      shift_q <= result_q;
      lost_q  <= 1'b0;
      ovl_q   <= 1'b0;
    end else if (cs_rise_w) begin
      frame_q <= FR_IDLE;
    end else if (late_w) begin
      lost_q  <= 1'b1;
      frame_q <= FR_HALT;
    end else if (over_w) begin
      ovl_q   <= 1'b1;
      frame_q <= FR_HALT;
    end else if (sclk_fall_w) begin
      falls_q <= falls_q + 1'b1;
      shift_q <= shift_once(shift_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= tenth_w;
  end

  assign dout_oe     = ~cs_level;
  assign dout        = dout_oe & shift_q[DATA_W-1];
  assign conv_start  = start_q;
  assign sync_err    = lost_q;
  assign overlen_err = ovl_q;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic dout,
  input logic dout_oe,
  input logic conv_start,
  input logic sync_err,
  input logic overlen_err,
  input logic cs_fall_w,
  input logic cs_rise_w,
  input logic busy_w
);
  // R2
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);
  // R2
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_w |=> dout_oe);
  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_w |=> !dout_oe);
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy_w);
  // R8
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err && !cs_fall_w |=> sync_err);
  // R9
  ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlen_err && !cs_fall_w |=> overlen_err);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_w |=> !sync_err && !overlen_err);
endmodule

bind adc_serial_port adc_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dout(dout), .dout_oe(dout_oe),
  .conv_start(conv_start), .sync_err(sync_err), .overlen_err(overlen_err),
  .cs_fall_w(cs_fall_w), .cs_rise_w(cs_rise_w), .busy_w(busy_w)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int DW = 10, MAXC = 16, HOLD = 4, LATE = 40, BUSY = 60;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, io_clk = 1'b0, conv_valid = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic dout, dout_oe, conv_start, sync_err, overlen_err;
  int n_chk = 0, n_fail = 0, n_start = 0;

  always #4 clk = ~clk;

  adc_serial_port #(.DATA_W(DW), .MAX_CLKS(MAXC), .CS_HOLD_CYC(HOLD),
                    .LATE_CYC(LATE), .BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk),
    .conv_data(conv_data), .conv_valid(conv_valid), .dout(dout),
    .dout_oe(dout_oe), .conv_start(conv_start), .sync_err(sync_err),
    .overlen_err(overlen_err)
  );

  always @(posedge clk) if (rst_n && conv_start) n_start <= n_start + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [DW-1:0] v);
    conv_data = v; conv_valid = 1'b1; cyc(1); conv_valid = 1'b0; cyc(1);
  endtask

  task automatic cs_set(input logic v);
    cs_n = v; cyc(HOLD + 6);
  endtask

  task automatic pulse();
    io_clk = 1'b1; cyc(5); io_clk = 1'b0; cyc(5);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int s0;
    logic [DW-1:0] v;
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk(!dout_oe && !dout, "R1 outputs", {dout_oe, dout}, 0);
    chk(!conv_start && !sync_err && !overlen_err, "R1 flags",
        {conv_start, sync_err, overlen_err}, 0);

    // R5: clocks with chip select high do nothing
    load(10'h3C5);
    s0 = n_start;
    for (int i = 0; i < 12; i++) pulse();
    chk(!dout_oe && !dout, "R5 idle outputs", {dout_oe, dout}, 0);
    chk(n_start == s0, "R5 no start", n_start - s0, 0);
    chk(!overlen_err, "R5 no overlen", overlen_err, 0);
    cs_set(1'b0);
    chk(dout == 1'b1, "R5 msb after idle clocks", dout, 1);
    cs_set(1'b1);

    // R2 R4 R6 sweep over result patterns
    for (int f = 0; f < 36; f++) begin
      if (f == 0) v = '0;
      else if (f == 1) v = '1;
      else if (f < 12) v = DW'(1) << (f - 2);
      else v = DW'((f * 97 + 13) & 10'h3FF);
      load(v);
      s0 = n_start;
      cs_set(1'b0);
      chk(dout_oe == 1'b1, "R2 oe on", dout_oe, 1);
      chk(dout == v[DW-1], "R2 msb", dout, v[DW-1]);
      for (int k = 1; k <= MAXC; k++) begin
        pulse();
        if (k < DW) chk(dout == v[DW-1-k], "R4 bit", dout, v[DW-1-k]);
        else        chk(dout == 1'b0, "R4 zero fill", dout, 0);
        if (k == DW) chk(n_start - s0 == 1, "R6 start after tenth", n_start - s0, 1);
      end
      chk(n_start - s0 == 1, "R6 single start", n_start - s0, 1);
      chk(!sync_err && !overlen_err, "R8 R9 clean frame", {sync_err, overlen_err}, 0);
      cs_set(1'b1);
      chk(!dout_oe && !dout, "R2 oe off", {dout_oe, dout}, 0);
      cyc(BUSY + 10);
    end

    // R3: short chip-select glitches are ignored
    cs_n = 1'b0; cyc(2); cs_n = 1'b1; cyc(12);
    chk(!dout_oe, "R3 low glitch", dout_oe, 0);
    load(10'h200);
    cs_set(1'b0);
    cs_n = 1'b1; cyc(2); cs_n = 1'b0; cyc(12);
    chk(dout_oe == 1'b1, "R3 high glitch", dout_oe, 1);
    cs_set(1'b1);
    cyc(BUSY + 10);

    // R10: result captured at chip-select fall only
    load(10'h2B4);
    cs_set(1'b0);
    for (int k = 1; k <= 3; k++) pulse();
    load(10'h14B);
    for (int k = 4; k < DW; k++) begin
      pulse();
      chk(dout == (((10'h2B4) >> (DW - 1 - k)) & 1), "R10 old bits kept", dout,
          ((10'h2B4) >> (DW - 1 - k)) & 1);
    end
    pulse();
    cs_set(1'b1);
    cyc(BUSY + 10);
    cs_set(1'b0);
    chk(dout == 1'b0, "R10 new msb", dout, 0);
    pulse();
    chk(dout == 1'b1, "R10 new bit8", dout, 1);
    cs_set(1'b1);
    cyc(BUSY + 10);

    // R7: transfer started inside busy window is refused
    load(10'h200);
    cs_set(1'b0);
    for (int k = 0; k < DW; k++) pulse();
    cs_set(1'b1);
    s0 = n_start;
    cs_set(1'b0);
    chk(dout == 1'b1, "R7 msb shown", dout, 1);
    for (int k = 0; k < DW; k++) pulse();
    chk(dout == 1'b1, "R7 no shift", dout, 1);
    chk(n_start == s0, "R7 no start", n_start - s0, 0);
    cs_set(1'b1);
    cyc(BUSY + 10);

    // R8: late eleventh clock
    load(10'h2AA);
    cs_set(1'b0);
    for (int k = 0; k < DW; k++) pulse();
    cyc(LATE + 20);
    chk(!sync_err, "R8 not yet", sync_err, 0);
    pulse();
    chk(sync_err == 1'b1, "R8 set", sync_err, 1);
    s0 = n_start;
    for (int k = 0; k < 10; k++) pulse();
    chk(!overlen_err, "R8 clocks ignored", overlen_err, 0);
    chk(n_start == s0, "R8 no start", n_start - s0, 0);
    cs_set(1'b1);
    chk(sync_err == 1'b1, "R8 held over cs rise", sync_err, 1);
    cyc(BUSY + 10);
    cs_set(1'b0);
    chk(!sync_err, "R8 cleared", sync_err, 0);
    chk(dout == 1'b1, "R8 msb after recovery", dout, 1);
    pulse();
    chk(dout == 1'b0, "R8 shift after recovery", dout, 0);
    cs_set(1'b1);
    cyc(BUSY + 10);

    // R9: over-length transfer
    load(10'h3FF);
    cs_set(1'b0);
    for (int k = 0; k < MAXC; k++) pulse();
    chk(!overlen_err, "R9 sixteen ok", overlen_err, 0);
    pulse();
    chk(overlen_err == 1'b1, "R9 set", overlen_err, 1);
    pulse();
    chk(overlen_err == 1'b1, "R9 held", overlen_err, 1);
    cs_set(1'b1);
    chk(overlen_err == 1'b1, "R9 held over cs rise", overlen_err, 1);
    cyc(BUSY + 10);
    cs_set(1'b0);
    chk(!overlen_err, "R9 cleared", overlen_err, 0);
    cs_set(1'b1);

    summary();
    $finish;
  end
endmodule